// File: doc/BRIEF.md
# Serial Word Shifter with Byte Reordering

This block is the shifting core of a master-mode serial peripheral port. It moves one word per transfer. On a start strobe it loads a parallel word and shifts it out on the data-out line, one bit per serial clock period. At the same time it captures the data-in line into a received word. The serial clock does not run free. It advances one half period for each cycle in which the external `tick` input is high, so the clock divider stays outside the block.

A two-bit mode code selects two options independently. The first reverses the byte order of the word on the wire. The second pauses the serial clock for an idle interval at every byte boundary. Both options apply only to full 32-bit words. When the length field selects a shorter word, the mode code is ignored. The received word passes through the same byte reordering in reverse, so the software-visible byte layout is the same in both directions.

When a transfer ends, a sticky completion flag is set. The flag is cleared by writing a one, and the interrupt output is the flag gated by an enable input.

Top module: `spi_word_shifter`

## Requirements
- R1: With mode code 00 and a 32-bit length, the 32 bits are sent most significant bit first, with no pause between bytes.
- R2: With mode code 10 and a 32-bit length, bits [7:0] go out first, then [15:8], then [23:16], then [31:24]. Each byte is sent most significant bit first, with no pause.
- R3: With mode code 11 and a 32-bit length, the byte order is unchanged. After bits 8, 16 and 24 the serial clock stays low for an extra 2*IDLE_PERIODS tick intervals, and the data-out line holds the last bit for that time.
- R4: Mode code 01 with a 32-bit length combines the reordering of R2 with the pauses of R3.
- R5: A nonzero length field N (0 means 32) sends the low N bits of the word, bit N-1 first. The mode code is ignored. The received word holds N bits in its low bits, with zeros above them.
- R6: The received word is captured in arrival order and then byte-reordered exactly as the transmit word was. In reordering modes, the first byte received ends up in bits [7:0].
- R7: The serial clock idles low and changes only in a cycle with `tick` high. A rising edge samples the data-in line. A falling edge moves the data-out line to the next bit. The first bit is on the data-out line from the cycle after start.
- R8: `busy` is high from the cycle after start until the flag is set, and falls in the same cycle. A start strobe while busy is ignored, as are mode and word changes.
- R9: The flag is set in the cycle after the final falling edge. `irq` is high exactly when the flag and `irq_en` are both high.
- R10: A write with value 1 clears the flag. A write with value 0 leaves it unchanged.
- R11: If a clearing write and a completion fall in the same cycle, the flag ends up set.
- R12: `rx_word` changes only at the completion of a transfer and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Half-period advance enable for the serial clock |
| start | input | 1 | Begin a transfer (taken only when idle) |
| tx_word | input | 32 | Word to transmit |
| mode | input | 2 | Reorder/idle option code |
| len_sel | input | 5 | Word length in bits, 0 meaning 32 |
| miso | input | 1 | Serial data in |
| irq_en | input | 1 | Interrupt enable |
| flag_clr_we | input | 1 | Write strobe for the completion flag |
| flag_clr_val | input | 1 | Written value; 1 clears the flag |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| rx_word | output | 32 | Last received word |
| flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench runs every mode code at several tick rates. It loops data-out back to data-in, sometimes inverted. A design that forgot to un-reorder the received word would return the bytes swapped. A design whose idle gap was off by one tick would drift the clock stream against the reference from the first byte boundary on.

Further cases target the boundaries of a transfer:
- a short length combined with a reordering mode, where a wrong design would swap or pause anyway;
- a start and a mode change during a transfer, which a wrong design would act on;
- a clear that coincides with the final falling edge, where a wrong priority would lose the completion;
- a zero-valued clear write, which must not drop the flag.

// File: rtl/spi_ws_pkg.sv
`timescale 1ns/1ps
package spi_ws_pkg;

    typedef enum logic [1:0] {
        XF_PLAIN    = 2'b00,
        XF_SWAP_GAP = 2'b01,
        XF_SWAP     = 2'b10,
        XF_GAP      = 2'b11
    } xfer_mode_e;

    function automatic logic mode_swaps(input xfer_mode_e m);
        return (m == XF_SWAP) || (m == XF_SWAP_GAP);
    endfunction

    function automatic logic mode_gaps(input xfer_mode_e m);
        return (m == XF_GAP) || (m == XF_SWAP_GAP);
    endfunction

endpackage

// File: rtl/spi_ws_order.sv
`timescale 1ns/1ps
module spi_ws_order #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int NBYTES = WORD_W / BYTE_W;

    logic [WORD_W-1:0] swapped;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign swapped[g*BYTE_W +: BYTE_W] = din[(NBYTES-1-g)*BYTE_W +: BYTE_W];
    end

    assign dout = en ? swapped : din;

endmodule

// File: rtl/spi_ws_engine.sv
`timescale 1ns/1ps
module spi_ws_engine #(
    parameter int WORD_W       = 32,
    parameter int BYTE_W       = 8,
    parameter int IDLE_PERIODS = 2,
    parameter int CNT_W        = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  nbits_i,
    input  logic              swap_i,
    input  logic              idle_en_i,
    input  logic [WORD_W-1:0] tx_i,
    input  logic              miso_i,
    input  logic [WORD_W-1:0] rx_ord_i,
    output logic [WORD_W-1:0] rx_raw_o,
    output logic              swap_o,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] rx_word_o
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam int GAP_W = $clog2(2*IDLE_PERIODS) + 1;

    typedef struct packed {
        logic              sck;
        logic              mosi;
        logic              busy;
        logic              gap;
        logic              idle_en;
        logic              swap;
        logic [GAP_W-1:0]  gap_cnt;
        logic [CNT_W-1:0]  left;
        logic [BIT_W-1:0]  in_byte;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] rx_sh;
        logic [WORD_W-1:0] rx_word;
    } eng_t;

    eng_t q, d;
    logic done;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy    = 1'b1;
                d.sck     = 1'b0;
                d.gap     = 1'b0;
                d.idle_en = idle_en_i;
                d.swap    = swap_i;
                d.left    = nbits_i;
                d.in_byte = '0;
                d.sh      = tx_i << (CNT_W'(WORD_W) - nbits_i);
                d.mosi    = d.sh[WORD_W-1];
                d.rx_sh   = '0;
            end
        end else if (tick_i) begin
            if (q.gap) begin
                if (q.gap_cnt == '0) begin
                    d.gap  = 1'b0;
                    d.sh   = q.sh << 1;
                    d.mosi = d.sh[WORD_W-1];
                end else begin
                    d.gap_cnt = q.gap_cnt - 1'b1;
                end
            end else if (!q.sck) begin
                d.sck   = 1'b1;
                d.rx_sh = {q.rx_sh[WORD_W-2:0], miso_i};
            end else begin
                d.sck = 1'b0;
                if (q.left == CNT_W'(1)) begin
                    d.busy    = 1'b0;
                    done      = 1'b1;
                    d.rx_word = rx_ord_i;
                end else begin
                    d.left    = q.left - 1'b1;
                    d.in_byte = q.in_byte + 1'b1;
                    if (q.idle_en && (q.in_byte == BIT_W'(BYTE_W-1))) begin
                        d.gap     = 1'b1;
                        d.gap_cnt = GAP_W'(2*IDLE_PERIODS-1);
                    end else begin
                        d.sh   = q.sh << 1;
                        d.mosi = d.sh[WORD_W-1];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_raw_o  = q.rx_sh;
    assign swap_o    = q.swap;
    assign sck_o     = q.sck;
    assign mosi_o    = q.mosi;
    assign busy_o    = q.busy;
    assign done_o    = done;
    assign rx_word_o = q.rx_word;

    p_sck_only_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(q.sck));
    p_gap_clock_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.gap |-> !q.sck);
    p_gap_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.gap && q.gap_cnt != '0) |=> $stable(q.mosi));
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start_i && !tick_i) |=> ($stable(q.left) && $stable(q.swap)));
    p_rx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(q.rx_word));

endmodule

// File: rtl/spi_ws_irq.sv
`timescale 1ns/1ps
module spi_ws_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic clr_we_i,
    input  logic clr_val_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    typedef struct packed {
        logic flag;
    } irq_t;

    irq_t q, d;
    logic clear_req;

    always_comb begin
        d         = q;
        clear_req = clr_we_i && clr_val_i;
        if (done_i)         d.flag = 1'b1;
        else if (clear_req) d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag_o = q.flag;
    assign irq_o  = q.flag & irq_en_i;

    p_set_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> flag_o);
    p_zero_write_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(clr_we_i && clr_val_i)) |=> flag_o);
    p_one_write_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && clr_we_i && clr_val_i) |=> !flag_o);
    p_collision_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && clr_we_i && clr_val_i) |=> flag_o);

endmodule

// File: rtl/spi_word_shifter.sv
`timescale 1ns/1ps
module spi_word_shifter
    import spi_ws_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int BYTE_W       = 8,
    parameter int IDLE_PERIODS = 2,
    parameter int LEN_W        = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [1:0]        mode,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic              miso,
    input  logic              irq_en,
    input  logic              flag_clr_we,
    input  logic              flag_clr_val,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic [WORD_W-1:0] rx_word,
    output logic              flag,
    output logic              irq
);
    localparam int CNT_W = LEN_W + 1;

    logic              full_word;
    logic              swap_req;
    logic              idle_req;
    logic [CNT_W-1:0]  nbits;
    logic [WORD_W-1:0] tx_ord;
    logic [WORD_W-1:0] rx_raw;
    logic [WORD_W-1:0] rx_ord;
    logic              swap_act;
    logic              done;

    assign full_word = (len_sel == '0);
    assign nbits     = full_word ? CNT_W'(WORD_W) : CNT_W'(len_sel);
    assign swap_req  = full_word && mode_swaps(xfer_mode_e'(mode));
    assign idle_req  = full_word && mode_gaps(xfer_mode_e'(mode));

    spi_ws_order #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_tx_order (
        .en(swap_req), .din(tx_word), .dout(tx_ord)
    );

    spi_ws_order #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_rx_order (
        .en(swap_act), .din(rx_raw), .dout(rx_ord)
    );

    spi_ws_engine #(
        .WORD_W(WORD_W), .BYTE_W(BYTE_W),
        .IDLE_PERIODS(IDLE_PERIODS), .CNT_W(CNT_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start),
        .nbits_i(nbits), .swap_i(swap_req), .idle_en_i(idle_req),
        .tx_i(tx_ord), .miso_i(miso), .rx_ord_i(rx_ord),
        .rx_raw_o(rx_raw), .swap_o(swap_act), .sck_o(sck),
        .mosi_o(mosi), .busy_o(busy), .done_o(done), .rx_word_o(rx_word)
    );

    spi_ws_irq u_irq (
        .clk(clk), .rst_n(rst_n), .done_i(done),
        .clr_we_i(flag_clr_we), .clr_val_i(flag_clr_val),
        .irq_en_i(irq_en), .flag_o(flag), .irq_o(irq)
    );

    p_busy_end_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> flag);
    p_idle_clock_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

endmodule

// File: tb/sim_spi_word_shifter.sv
`timescale 1ns/1ps
module sim_spi_word_shifter;
    localparam int IDLE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, start = 1'b0;
    logic [31:0] tx_word = '0;
    logic [1:0]  mode = '0;
    logic [4:0]  len_sel = '0;
    logic        miso_inv = 1'b0;
    logic        irq_en = 1'b0, flag_clr_we = 1'b0, flag_clr_val = 1'b0;
    logic        sck, mosi, busy, flag, irq, miso;
    logic [31:0] rx_word;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R7 R9 R12 reset";

    // 250 MHz clock: 4 ns period
    always #2 clk = ~clk;

    assign miso = mosi ^ miso_inv;

    spi_word_shifter u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .tx_word(tx_word),
        .mode(mode), .len_sel(len_sel), .miso(miso), .irq_en(irq_en),
        .flag_clr_we(flag_clr_we), .flag_clr_val(flag_clr_val), .sck(sck),
        .mosi(mosi), .busy(busy), .rx_word(rx_word), .flag(flag), .irq(irq)
    );

    // reference model: queue of expected {last, sck, mosi} per tick
    logic [2:0]  m_q[$];
    logic        m_busy = 0, m_sck = 0, m_mosi = 0, m_flag = 0, m_done = 0;
    logic [31:0] m_rx = '0, m_rx_next = '0;
    logic [2:0]  item;

    task automatic build_model();
        int n;
        bit rev, gp;
        logic [31:0] w, mask;
        n    = (len_sel == 0) ? 32 : int'(len_sel);
        rev  = (len_sel == 0) && (mode == 2'b01 || mode == 2'b10);
        gp   = (len_sel == 0) && (mode == 2'b01 || mode == 2'b11);
        w    = rev ? {tx_word[7:0], tx_word[15:8], tx_word[23:16], tx_word[31:24]} : tx_word;
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
        m_q.delete();
        for (int i = 0; i < n; i++) begin
            m_q.push_back({1'b0, 1'b1, w[n-1-i]});
            if (i == n-1) begin
                m_q.push_back({1'b1, 1'b0, w[n-1-i]});
            end else if (gp && (i % 8) == 7) begin
                for (int k = 0; k < 2*IDLE; k++) m_q.push_back({1'b0, 1'b0, w[n-1-i]});
                m_q.push_back({1'b0, 1'b0, w[n-2-i]});
            end else begin
                m_q.push_back({1'b0, 1'b0, w[n-2-i]});
            end
        end
        m_sck     = 1'b0;
        m_mosi    = w[n-1];
        m_busy    = 1'b1;
        m_rx_next = (tx_word ^ {32{miso_inv}}) & mask;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_busy = 0; m_sck = 0; m_mosi = 0; m_flag = 0; m_rx = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (tick) begin
                    item   = m_q.pop_front();
                    m_sck  = item[1];
                    m_mosi = item[0];
                    if (item[2]) begin
                        m_busy = 0;
                        m_done = 1;
                        m_rx   = m_rx_next;
                    end
                end
            end else if (start) begin
                build_model();
            end
            if (m_done) m_flag = 1;
            else if (flag_clr_we && flag_clr_val) m_flag = 0;
        end
    end

    task automatic chk(input string sig, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, sig, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk("sck", {31'd0, sck}, {31'd0, m_sck});
        chk("mosi", {31'd0, mosi}, {31'd0, m_mosi});
        chk("busy(R8)", {31'd0, busy}, {31'd0, m_busy});
        chk("flag(R9)", {31'd0, flag}, {31'd0, m_flag});
        chk("irq(R9)", {31'd0, irq}, {31'd0, m_flag & irq_en});
        chk("rx_word(R12)", rx_word, m_rx);
    end

    task automatic xfer(input logic [31:0] w, input logic [1:0] md, input logic [4:0] ln,
                        input int div, input bit inv, input bit clr_last, input bit restart);
        int cyc;
        @(posedge clk); #1;
        tx_word = w; mode = md; len_sel = ln; miso_inv = inv; start = 1; tick = 0;
        @(posedge clk); #1;
        start = 0;
        cyc = 0;
        while (m_busy) begin
            cyc++;
            tick = ((cyc % div) == 0);
            flag_clr_we  = clr_last && tick && (m_q.size() == 1);
            flag_clr_val = flag_clr_we;
            if (restart && cyc == 4) begin
                start = 1; tx_word = ~w; mode = ~md;
            end else begin
                start = 0;
            end
            @(posedge clk); #1;
        end
        tick = 0; start = 0; flag_clr_we = 0; flag_clr_val = 0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic write_clr(input bit val);
        @(posedge clk); #1;
        flag_clr_we = 1; flag_clr_val = val;
        @(posedge clk); #1;
        flag_clr_we = 0; flag_clr_val = 0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        irq_en = 1;
        repeat (2) @(posedge clk);

        cur_req = "R1 R7";
        xfer(32'hA5C3_1E7F, 2'b00, 5'd0, 1, 0, 0, 0);
        cur_req = "R10 clear"; write_clr(1);

        cur_req = "R2 R8 restart ignored";
        xfer(32'h1234_5678, 2'b10, 5'd0, 3, 0, 0, 1);
        cur_req = "R10 clear"; write_clr(1);

        cur_req = "R3 idle gap";
        xfer(32'hF00F_55AA, 2'b11, 5'd0, 2, 0, 0, 0);

        cur_req = "R4 R6 swap+gap inverted";
        xfer(32'h8143_C2E1, 2'b01, 5'd0, 1, 1, 0, 0);

        cur_req = "R5 short length mode ignored";
        xfer(32'hFFFF_FABC, 2'b01, 5'd12, 2, 0, 0, 0);
        xfer(32'h0000_0001, 2'b10, 5'd1, 1, 1, 0, 0);
        xfer(32'h7ACE_BEEF, 2'b11, 5'd31, 1, 0, 0, 0);

        cur_req = "R9 irq gating";
        irq_en = 0;
        repeat (3) @(posedge clk);
        #1 irq_en = 1;
        cur_req = "R10 zero write";
        write_clr(0);
        cur_req = "R10 one write";
        write_clr(1);

        cur_req = "R11 clear meets completion";
        xfer(32'h0F1E_2D3C, 2'b00, 5'd0, 1, 0, 1, 0);
        cur_req = "R10 clear";
        write_clr(1);

        cur_req = "R6 R12 swap inverted slow";
        xfer(32'hDEAD_0B0E, 2'b10, 5'd0, 4, 1, 0, 0);

        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule